// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit adder. It takes two operands and a carry-in and returns the 16-bit sum and the carry-out. The operand bits are split into four 4-bit groups. Each group works out, for every bit, whether that bit creates a carry (both operand bits set) and whether it passes one on (either operand bit set). From these it derives flattened carries inside the group and a single group-level propagate and generate pair.

A second-level lookahead unit takes the four group pairs and the external carry-in. It produces the carry into every group, and the final carry-out, as two-level sum-of-products terms. No carry ripples from one group to the next, so the longest path stays at a handful of gate levels instead of growing with the width. The block also brings out the per-group propagate and generate pairs and one whole-adder pair, so that a further lookahead level can be stacked on top of several copies.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals (`a_in` + `b_in` + `cin`) modulo 2^16 for every input combination.
- R2: `cout` is 1 exactly when `a_in` + `b_in` + `cin` is 2^16 or more.
- R3: Bit k of `grp_p_out` (group k covers operand bits 4k+3 down to 4k) is 1 exactly when every bit of `a_in | b_in` in that group is 1.
- R4: Bit k of `grp_g_out` is 1 exactly when the 4-bit slices of `a_in` and `b_in` for group k, added with no carry-in, overflow 4 bits.
- R5: `blk_p_out` is 1 exactly when all 16 bits of `a_in | b_in` are 1.
- R6: `blk_g_out` is 1 exactly when `a_in` + `b_in` with no carry-in is 2^16 or more, whatever `cin` is.
- R7: `cout` always equals `blk_g_out | (blk_p_out & cin)`.
- R8: For `a_in` = 0x1A33, `b_in` = 0xE5EB and `cin` = 0, `grp_p_out` = 4'b1110, `grp_g_out` = 4'b0010, `cout` = 1 and `sum_out` = 0x001E.
- R9: A carry-in that travels through every group (`a_in` = 0xFFFF, `b_in` = 0, `cin` = 1) gives `sum_out` = 0, `cout` = 1, `blk_p_out` = 1 and `blk_g_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_p_out | output | 4 | Propagate of each 4-bit group, bit k for group k |
| grp_g_out | output | 4 | Generate of each 4-bit group, bit k for group k |
| blk_p_out | output | 1 | Propagate of the whole 16-bit adder |
| blk_g_out | output | 1 | Generate of the whole 16-bit adder |

## Verification
A carry that is generated in one group and must cross groups that only propagate is the case where both lookahead levels act at the same time. The second-level carry has to agree with the flattened carries inside the receiving groups. The bench sets this up with operands such as 0x00FF + 0x0001, 0x0FF8 + 0x0008 and the all-propagate chain with a carry-in. It judges every sum bit, the carry-out and all group pairs against plain integer arithmetic. A deterministic pseudo-random sweep then repeats the same comparison over many mixed generate and propagate patterns.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // widest lookahead span the shared carry function supports
    localparam int LA_MAX = 8;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // Flattened two-level carries for an n-bit span (n <= LA_MAX).
    // c[k] = OR over j<k of (g[j] & p[j+1..k-1]) OR (c0 & p[0..k-1])
    function automatic logic [LA_MAX:0] la_carries(
        input logic [LA_MAX-1:0] p,
        input logic [LA_MAX-1:0] g,
        input logic              c0,
        input int                n
    );
        logic [LA_MAX:0] c;
        logic            t;
        c    = '0;
        c[0] = c0;
        for (int k = 1; k <= LA_MAX; k++) begin
            if (k <= n) begin
                t = c0;
                for (int m = 0; m < LA_MAX; m++)
                    if (m < k) t = t & p[m];
                c[k] = t;
                for (int j = 0; j < LA_MAX; j++) begin
                    if (j < k) begin
                        t = g[j];
                        for (int m = 0; m < LA_MAX; m++)
                            if (m > j && m < k) t = t & p[m];
                        c[k] = c[k] | t;
                    end
                end
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/cla_group_pg.sv
module cla_group_pg
    import cla_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] a_slice,
    input  logic [GRP_W-1:0] b_slice,
    output logic [GRP_W-1:0] bit_p,
    output logic [GRP_W-1:0] bit_g,
    output pg_t              grp
);

    logic [LA_MAX-1:0] p_pad;
    logic [LA_MAX-1:0] g_pad;
    logic [LA_MAX:0]   c_loc;

    always_comb begin
        bit_p = a_slice | b_slice;
        bit_g = a_slice & b_slice;
        p_pad = '0;
        g_pad = '0;
        p_pad[GRP_W-1:0] = bit_p;
        g_pad[GRP_W-1:0] = bit_g;
        c_loc = la_carries(p_pad, g_pad, 1'b0, GRP_W);
        grp.p = &bit_p;
        grp.g = c_loc[GRP_W];

        // group generate means the slices overflow on their own
        assert_grp_g_R4: assert (grp.g ==
            (({1'b0, a_slice} + {1'b0, b_slice}) >> GRP_W) != 0)
            else $error("group generate disagrees with slice overflow");
        // group propagate guarantees a carry-out when a carry comes in
        assert_grp_p_R3: assert (!grp.p ||
            ((({1'b0, a_slice} + {1'b0, b_slice} + 1) >> GRP_W) != 0))
            else $error("group propagate set without carry pass-through");
    end

endmodule

// File: rtl/cla_group_sum.sv
module cla_group_sum
    import cla_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] bit_p,
    input  logic [GRP_W-1:0] bit_g,
    input  logic             grp_cin,
    output logic [GRP_W-1:0] sum
);

    logic [LA_MAX-1:0] p_pad;
    logic [LA_MAX-1:0] g_pad;
    logic [LA_MAX:0]   c_loc;
    logic [GRP_W-1:0]  half;

    always_comb begin
        p_pad = '0;
        g_pad = '0;
        p_pad[GRP_W-1:0] = bit_p;
        g_pad[GRP_W-1:0] = bit_g;
        c_loc = la_carries(p_pad, g_pad, grp_cin, GRP_W);
        half  = bit_p & ~bit_g;
        sum   = half ^ c_loc[GRP_W-1:0];

        // a+b+cin rebuilt as half-sum + 2*generate + cin
        assert_grp_sum_R1: assert ({c_loc[GRP_W], sum} ==
            ({1'b0, half} + {bit_g, 1'b0} + {{GRP_W{1'b0}}, grp_cin}))
            else $error("group sum disagrees with arithmetic");
    end

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
#(
    parameter int N_GRP = 4
) (
    input  pg_t [N_GRP-1:0]  grp,
    input  logic             cin,
    output logic [N_GRP-1:0] grp_cin,
    output logic             cout,
    output logic             blk_p,
    output logic             blk_g
);

    logic [LA_MAX-1:0] gp_pad;
    logic [LA_MAX-1:0] gg_pad;
    logic [LA_MAX:0]   c_in;
    logic [LA_MAX:0]   c_zero;

    always_comb begin
        gp_pad = '0;
        gg_pad = '0;
        for (int k = 0; k < N_GRP; k++) begin
            gp_pad[k] = grp[k].p;
            gg_pad[k] = grp[k].g;
        end
        c_in    = la_carries(gp_pad, gg_pad, cin,  N_GRP);
        c_zero  = la_carries(gp_pad, gg_pad, 1'b0, N_GRP);
        grp_cin = c_in[N_GRP-1:0];
        cout    = c_in[N_GRP];
        blk_g   = c_zero[N_GRP];
        blk_p   = &gp_pad[N_GRP-1:0];

        // flattened group carries must match the one-step group relation
        for (int k = 0; k < N_GRP; k++) begin
            assert_ripple_R2: assert (c_in[k+1] ==
                (gg_pad[k] | (gp_pad[k] & c_in[k])))
                else $error("group carry %0d breaks ripple relation", k);
        end
        assert_blk_R7: assert (cout == (blk_g | (blk_p & cin)))
            else $error("carry-out disagrees with block pair");
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int GRP_W = 4,
    parameter int N_GRP = 4
) (
    input  logic [GRP_W*N_GRP-1:0] a_in,
    input  logic [GRP_W*N_GRP-1:0] b_in,
    input  logic                   cin,
    output logic [GRP_W*N_GRP-1:0] sum_out,
    output logic                   cout,
    output logic [N_GRP-1:0]       grp_p_out,
    output logic [N_GRP-1:0]       grp_g_out,
    output logic                   blk_p_out,
    output logic                   blk_g_out
);

    localparam int W = GRP_W * N_GRP;

    pg_t [N_GRP-1:0]  grp_pg;
    logic [N_GRP-1:0] grp_cin;
    logic [W-1:0]     bit_p;
    logic [W-1:0]     bit_g;

    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
        cla_group_pg #(.GRP_W(GRP_W)) u_pg (
            .a_slice (a_in[gi*GRP_W +: GRP_W]),
            .b_slice (b_in[gi*GRP_W +: GRP_W]),
            .bit_p   (bit_p[gi*GRP_W +: GRP_W]),
            .bit_g   (bit_g[gi*GRP_W +: GRP_W]),
            .grp     (grp_pg[gi])
        );

        cla_group_sum #(.GRP_W(GRP_W)) u_sum (
            .bit_p   (bit_p[gi*GRP_W +: GRP_W]),
            .bit_g   (bit_g[gi*GRP_W +: GRP_W]),
            .grp_cin (grp_cin[gi]),
            .sum     (sum_out[gi*GRP_W +: GRP_W])
        );

        assign grp_p_out[gi] = grp_pg[gi].p;
        assign grp_g_out[gi] = grp_pg[gi].g;
    end

    cla_carry_unit #(.N_GRP(N_GRP)) u_cu (
        .grp     (grp_pg),
        .cin     (cin),
        .grp_cin (grp_cin),
        .cout    (cout),
        .blk_p   (blk_p_out),
        .blk_g   (blk_g_out)
    );

endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic          cin = 1'b0;
    logic [W-1:0]  sum_out;
    logic          cout;
    logic [NG-1:0] grp_p_out;
    logic [NG-1:0] grp_g_out;
    logic          blk_p_out;
    logic          blk_g_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla16_adder u_dut (
        .a_in(a_in), .b_in(b_in), .cin(cin),
        .sum_out(sum_out), .cout(cout),
        .grp_p_out(grp_p_out), .grp_g_out(grp_g_out),
        .blk_p_out(blk_p_out), .blk_g_out(blk_g_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (a=%h b=%h cin=%b)",
                     tag, act, exp, a_in, b_in, cin);
        end
    endtask

    // drive at falling edge, sample mid low phase
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        @(negedge clk);
        a_in = a; b_in = b; cin = c;
        #(CLK_PERIOD/4);
    endtask

    // compare all outputs against integer arithmetic
    task automatic check_all();
        logic [W:0]    full;
        logic [W:0]    nocin;
        logic [NG-1:0] ep;
        logic [NG-1:0] eg;
        logic [4:0]    gs;
        full  = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin};
        nocin = {1'b0, a_in} + {1'b0, b_in};
        for (int k = 0; k < NG; k++) begin
            ep[k] = &((a_in | b_in) >> (4*k) & 16'hF) == 1'b0 ? 1'b0 : 1'b0;
            ep[k] = (((a_in | b_in) >> (4*k)) & 16'hF) == 16'hF;
            gs    = {1'b0, 4'((a_in >> (4*k)) & 16'hF)} + {1'b0, 4'((b_in >> (4*k)) & 16'hF)};
            eg[k] = gs[4];
        end
        chk("R1 sum", 32'(sum_out), 32'(full[W-1:0]));
        chk("R2 cout", 32'(cout), 32'(full[W]));
        chk("R3 group P", 32'(grp_p_out), 32'(ep));
        chk("R4 group G", 32'(grp_g_out), 32'(eg));
        chk("R5 block P", 32'(blk_p_out), 32'((a_in | b_in) == 16'hFFFF));
        chk("R6 block G", 32'(blk_g_out), 32'(nocin[W]));
        chk("R7 cout vs pair", 32'(cout), 32'(blk_g_out | (blk_p_out & cin)));
    endtask

    task automatic t_zero();
        apply(16'h0000, 16'h0000, 1'b0);
        chk("R1 zero sum", 32'(sum_out), 32'h0);
        chk("R2 zero cout", 32'(cout), 32'h0);
        check_all();
    endtask

    task automatic t_example();
        apply(16'h1A33, 16'hE5EB, 1'b0);
        chk("R8 P", 32'(grp_p_out), 32'hE);
        chk("R8 G", 32'(grp_g_out), 32'h2);
        chk("R8 cout", 32'(cout), 32'h1);
        chk("R8 sum", 32'(sum_out), 32'h001E);
        check_all();
    endtask

    task automatic t_chain();
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R9 sum", 32'(sum_out), 32'h0);
        chk("R9 cout", 32'(cout), 32'h1);
        chk("R9 blk P", 32'(blk_p_out), 32'h1);
        chk("R9 blk G", 32'(blk_g_out), 32'h0);
        check_all();
        apply(16'hFFFF, 16'h0000, 1'b0);
        chk("R9 no cin sum", 32'(sum_out), 32'hFFFF);
        chk("R7 no cin cout", 32'(cout), 32'h0);
    endtask

    // generate in one group crossing propagate-only groups
    task automatic t_cross();
        apply(16'h00FF, 16'h0001, 1'b0); check_all();
        apply(16'h0FF8, 16'h0008, 1'b0); check_all();
        apply(16'hF000, 16'h1000, 1'b0);
        chk("R6 top-group generate", 32'(blk_g_out), 32'h1);
        check_all();
        apply(16'h8000, 16'h7FFF, 1'b1); check_all();
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[15:0], lfsr[31:16] ^ 16'(i * 16'h3D5), lfsr[7]);
            check_all();
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_zero();
        t_example();
        t_chain();
        t_cross();
        t_sweep();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule